// File: doc/BRIEF.md
# Indirect-Access IDE Configuration Register Bank

This block is the small configuration store of a two-channel IDE controller. A host bus reaches it through two byte ports: writing a byte to the base port selects a register, and a transfer at the base port plus four reads or writes the selected register. The base port sits at 0x178 unless a board strap moves it to 0x078. Host accesses to any other address leave the block untouched.

The bank holds a configuration byte with a read-only revision field and a read-only copy of the strap. It also holds a control byte, seven per-drive timing bytes, a read-ahead burst byte and a scratch byte. Software uses the scratch byte to probe for the part. A few fields are decoded into level outputs for the rest of the controller: the secondary-channel enable, a read-ahead disable for each of the four drives, and fast device-select timing.

Reads are registered. The byte appears on `host_rdata` with a one-cycle `host_rvalid` pulse on the clock after the read strobe.

Top module: `ide_ixcfg_regs`

## Requirements
- R1: A write at the base port loads the 8-bit register index. A read at the base port returns that index. A write at the base port plus 4 updates the selected register, and a read there returns it.
- R2: The base port is 0x178 while `strap_alt_base` is 0 and 0x078 while it is 1. Reads and writes at any other address change no state and produce no `host_rvalid`.
- R3: In the configuration byte at index 0x50, bits 1:0 always read the nonzero revision (default 1) and bit 5 reads `strap_alt_base`. Writes to these three bits are ignored. Bits 7:6 and 4:2 are read/write.
- R4: In the control byte at index 0x51, bit 3 drives `sec_chan_en`, bit 6 drives `ra_dis[0]` and bit 7 drives `ra_dis[1]`.
- R5: In the byte at index 0x57, bit 2 drives `ra_dis[2]` and bit 3 drives `ra_dis[3]`.
- R6: `fast_dsel` is 1 only while control bits 0, 1, 2 and 5 (mask 0x27) are all set. Any subset leaves it at 0.
- R7: Index 0x5B is a scratch byte that reads back the last value written to it.
- R8: After reset the burst byte at index 0x59 reads 0x40, and every other writable byte, the index and all decoded outputs read 0.
- R9: A read of an unimplemented index (for example 0x5A or 0x10) returns 0x00. A write to such an index changes no register.
- R10: For every read strobe at a port, `host_rvalid` pulses for exactly one cycle on the following clock, with the data on `host_rdata`. Without a read strobe, `host_rvalid` stays low.
- R11: The timing bytes at indices 0x52 through 0x58 store and return full 8-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt_base | input | 1 | Board strap: 0 selects base 0x178, 1 selects base 0x078 |
| host_addr | input | ADDR_W (16) | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| host_rvalid | output | 1 | One-cycle pulse marking `host_rdata` valid |
| sec_chan_en | output | 1 | Secondary-channel enable |
| ra_dis | output | 4 | Read-ahead disable per drive, bit n for drive n |
| fast_dsel | output | 1 | Fast device-select timing |

## Verification
The hardest case to reach from the ports is traffic aimed at the wrong base. To cover it, the stimulus first points the shared index at the control byte through the valid base. It then writes an all-ones byte through the other base, or with the strap flipped through the old base. If that decode leaked, the write would visibly raise every decoded output. The revision and strap bits are checked the same way: all ones are written over them, then the byte is read back under both strap settings.

// File: rtl/ixcfg_pkg.sv
package ixcfg_pkg;

   localparam int unsigned BYTE_W = 8;

   // register indices (neighbour decoders depend on these)
   localparam logic [7:0] IX_CFG      = 8'h50;
   localparam logic [7:0] IX_CTRL     = 8'h51;
   localparam logic [7:0] IX_TIM_LO   = 8'h52;
   localparam logic [7:0] IX_TIM_HI   = 8'h58;
   localparam logic [7:0] IX_TIM_SEC  = 8'h57;
   localparam logic [7:0] IX_BURST    = 8'h59;
   localparam logic [7:0] IX_SCRATCH  = 8'h5B;

   localparam int unsigned NUM_TIM  = int'(IX_TIM_HI - IX_TIM_LO) + 1;
   localparam int unsigned SEC_SLOT = int'(IX_TIM_SEC - IX_TIM_LO);

   // configuration byte layout
   localparam int unsigned CFG_STRAP_BIT = 5;
   localparam logic [7:0]  CFG_RO_MASK   = 8'h23;
   localparam logic [7:0]  CFG_RW_MASK   = ~CFG_RO_MASK;

   // control byte layout
   localparam int unsigned CTRL_SEC_BIT = 3;
   localparam int unsigned CTRL_RA0_BIT = 6;
   localparam int unsigned CTRL_RA1_BIT = 7;
   localparam logic [7:0]  FAST_MASK    = 8'h27;

   // secondary timing byte layout
   localparam int unsigned SEC_RA2_BIT = 2;
   localparam int unsigned SEC_RA3_BIT = 3;

   typedef struct packed {
      logic ix_wr;
      logic dat_wr;
      logic ix_rd;
      logic dat_rd;
   } port_hit_t;

endpackage

// File: rtl/ixcfg_port_decode.sv
module ixcfg_port_decode
   import ixcfg_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter logic [31:0] BASE_DEF = 32'h178,
   parameter logic [31:0] BASE_ALT = 32'h078,
   parameter int unsigned DATA_OFS = 4
) (
   input  logic              strap_alt,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output port_hit_t         hit
);

   localparam logic [ADDR_W-1:0] IX_DEF  = ADDR_W'(BASE_DEF);
   localparam logic [ADDR_W-1:0] IX_ALT  = ADDR_W'(BASE_ALT);
   localparam logic [ADDR_W-1:0] DAT_DEF = ADDR_W'(BASE_DEF + DATA_OFS);
   localparam logic [ADDR_W-1:0] DAT_ALT = ADDR_W'(BASE_ALT + DATA_OFS);

   if (DATA_OFS == 0) begin : g_bad_ofs
      $error("ixcfg_port_decode: DATA_OFS must be nonzero");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
      $error("ixcfg_port_decode: ADDR_W out of range");
   end
   if (BASE_DEF + DATA_OFS >= (64'd1 << ADDR_W)) begin : g_bad_base
      $error("ixcfg_port_decode: base does not fit ADDR_W");
   end

   logic [ADDR_W-1:0] ix_addr;
   logic [ADDR_W-1:0] dat_addr;
   logic              on_ix;
   logic              on_dat;

   always_comb begin
      ix_addr  = strap_alt ? IX_ALT  : IX_DEF;
      dat_addr = strap_alt ? DAT_ALT : DAT_DEF;
      on_ix    = (addr == ix_addr);
      on_dat   = (addr == dat_addr);
      hit.ix_wr  = wr & on_ix;
      hit.dat_wr = wr & on_dat;
      hit.ix_rd  = rd & on_ix;
      hit.dat_rd = rd & on_dat;
   end

endmodule

// File: rtl/ixcfg_reg_bank.sv
module ixcfg_reg_bank
   import ixcfg_pkg::*;
#(
   parameter logic [7:0] BURST_RST = 8'h40
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [7:0]                  index,
   input  logic [7:0]                  wdata,
   output logic [7:0]                  cfg_rw_q,
   output logic [7:0]                  ctrl_q,
   output logic [NUM_TIM-1:0][7:0]     tim_q,
   output logic [7:0]                  burst_q,
   output logic [7:0]                  scratch_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_rw_q  <= '0;
         ctrl_q    <= '0;
         burst_q   <= BURST_RST;
         scratch_q <= '0;
      end else if (wr_en) begin
         if (index == IX_CFG)     cfg_rw_q  <= wdata & CFG_RW_MASK;
         if (index == IX_CTRL)    ctrl_q    <= wdata;
         if (index == IX_BURST)   burst_q   <= wdata;
         if (index == IX_SCRATCH) scratch_q <= wdata;
      end
   end

   for (genvar i = 0; i < NUM_TIM; i++) begin : g_tim
      localparam logic [7:0] MY_IX = IX_TIM_LO + 8'(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tim_q[i] <= '0;
         end else if (wr_en && index == MY_IX) begin
            tim_q[i] <= wdata;
         end
      end
   end

endmodule

// File: rtl/ixcfg_read_mux.sv
module ixcfg_read_mux
   import ixcfg_pkg::*;
#(
   parameter logic [1:0] REVISION = 2'd1
) (
   input  logic [7:0]              index,
   input  logic                    strap_alt,
   input  logic [7:0]              cfg_rw_q,
   input  logic [7:0]              ctrl_q,
   input  logic [NUM_TIM-1:0][7:0] tim_q,
   input  logic [7:0]              burst_q,
   input  logic [7:0]              scratch_q,
   output logic [7:0]              rd_byte
);

   if (REVISION == 2'd0) begin : g_bad_rev
      $error("ixcfg_read_mux: REVISION must be nonzero");
   end

   logic [7:0] cfg_view;

   always_comb begin
      cfg_view = cfg_rw_q & CFG_RW_MASK;
      cfg_view[1:0] = REVISION;
      cfg_view[CFG_STRAP_BIT] = strap_alt;
   end

   always_comb begin
      rd_byte = '0;
      unique case (index)
         IX_CFG:     rd_byte = cfg_view;
         IX_CTRL:    rd_byte = ctrl_q;
         IX_BURST:   rd_byte = burst_q;
         IX_SCRATCH: rd_byte = scratch_q;
         default: begin
            for (int i = 0; i < NUM_TIM; i++) begin
               if (index == IX_TIM_LO + 8'(i)) rd_byte = tim_q[i];
            end
         end
      endcase
   end

endmodule

// File: rtl/ide_ixcfg_regs.sv
module ide_ixcfg_regs
   import ixcfg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter logic [31:0] BASE_DEF  = 32'h178,
   parameter logic [31:0] BASE_ALT  = 32'h078,
   parameter int unsigned DATA_OFS  = 4,
   parameter logic [1:0]  REVISION  = 2'd1,
   parameter logic [7:0]  BURST_RST = 8'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_alt_base,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   output logic              host_rvalid,
   output logic              sec_chan_en,
   output logic [3:0]        ra_dis,
   output logic              fast_dsel
);

   port_hit_t              hit;
   logic [7:0]             idx_q;
   logic [7:0]             cfg_rw_q;
   logic [7:0]             ctrl_q;
   logic [NUM_TIM-1:0][7:0] tim_q;
   logic [7:0]             burst_q;
   logic [7:0]             scratch_q;
   logic [7:0]             rd_byte;

   ixcfg_port_decode #(
      .ADDR_W  (ADDR_W),
      .BASE_DEF(BASE_DEF),
      .BASE_ALT(BASE_ALT),
      .DATA_OFS(DATA_OFS)
   ) u_dec (
      .strap_alt(strap_alt_base),
      .addr     (host_addr),
      .wr       (host_wr),
      .rd       (host_rd),
      .hit      (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q <= '0;
      else if (hit.ix_wr) idx_q <= host_wdata;
   end

   ixcfg_reg_bank #(.BURST_RST(BURST_RST)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (hit.dat_wr),
      .index    (idx_q),
      .wdata    (host_wdata),
      .cfg_rw_q (cfg_rw_q),
      .ctrl_q   (ctrl_q),
      .tim_q    (tim_q),
      .burst_q  (burst_q),
      .scratch_q(scratch_q)
   );

   ixcfg_read_mux #(.REVISION(REVISION)) u_rmux (
      .index    (idx_q),
      .strap_alt(strap_alt_base),
      .cfg_rw_q (cfg_rw_q),
      .ctrl_q   (ctrl_q),
      .tim_q    (tim_q),
      .burst_q  (burst_q),
      .scratch_q(scratch_q),
      .rd_byte  (rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata  <= '0;
         host_rvalid <= 1'b0;
      end else begin
         host_rvalid <= hit.ix_rd | hit.dat_rd;
         if (hit.ix_rd)       host_rdata <= idx_q;
         else if (hit.dat_rd) host_rdata <= rd_byte;
      end
   end

   always_comb begin
      sec_chan_en = ctrl_q[CTRL_SEC_BIT];
      ra_dis      = {tim_q[SEC_SLOT][SEC_RA3_BIT], tim_q[SEC_SLOT][SEC_RA2_BIT],
                     ctrl_q[CTRL_RA1_BIT], ctrl_q[CTRL_RA0_BIT]};
      fast_dsel   = &(ctrl_q | ~FAST_MASK);
   end

endmodule

// File: rtl/ixcfg_checker.sv
module ixcfg_checker #(
   parameter int unsigned ADDR_W   = 16,
   parameter logic [31:0] BASE_DEF = 32'h178,
   parameter logic [31:0] BASE_ALT = 32'h078,
   parameter int unsigned DATA_OFS = 4,
   parameter logic [1:0]  REVISION = 2'd1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strap_alt_base,
   input logic [ADDR_W-1:0] host_addr,
   input logic              host_wr,
   input logic              host_rd,
   input logic [7:0]        host_rdata,
   input logic              host_rvalid,
   input logic              sec_chan_en,
   input logic [3:0]        ra_dis,
   input logic              fast_dsel,
   input logic [7:0]        idx_q
);

   logic [ADDR_W-1:0] c_ix;
   logic [ADDR_W-1:0] c_dat;
   assign c_ix  = strap_alt_base ? ADDR_W'(BASE_ALT) : ADDR_W'(BASE_DEF);
   assign c_dat = strap_alt_base ? ADDR_W'(BASE_ALT + DATA_OFS)
                                 : ADDR_W'(BASE_DEF + DATA_OFS);

   p_rvalid_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && (host_addr == c_ix || host_addr == c_dat) |=> host_rvalid);

   p_rvalid_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |-> $past(host_rd));

   p_rev_strap_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && host_addr == c_dat && idx_q == 8'h50
      |=> host_rdata[1:0] == REVISION && host_rdata[5] == $past(strap_alt_base));

   p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && host_addr == c_dat && idx_q == 8'h5A |=> host_rdata == 8'h00);

   p_outs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !host_wr |=> $stable({sec_chan_en, ra_dis, fast_dsel}));

endmodule

bind ide_ixcfg_regs ixcfg_checker #(
   .ADDR_W  (ADDR_W),
   .BASE_DEF(BASE_DEF),
   .BASE_ALT(BASE_ALT),
   .DATA_OFS(DATA_OFS),
   .REVISION(REVISION)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .strap_alt_base(strap_alt_base),
   .host_addr     (host_addr),
   .host_wr       (host_wr),
   .host_rd       (host_rd),
   .host_rdata    (host_rdata),
   .host_rvalid   (host_rvalid),
   .sec_chan_en   (sec_chan_en),
   .ra_dis        (ra_dis),
   .fast_dsel     (fast_dsel),
   .idx_q         (idx_q)
);

// File: tb/test_ide_ixcfg_regs.sv
module test_ide_ixcfg_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_alt_base = 1'b0;
   logic [15:0] host_addr = '0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        host_rvalid;
   logic        sec_chan_en;
   logic [3:0]  ra_dis;
   logic        fast_dsel;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit ended = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   ide_ixcfg_regs i_ide_ixcfg_regs (
      .clk(clk), .rst_n(rst_n), .strap_alt_base(strap_alt_base),
      .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
      .sec_chan_en(sec_chan_en), .ra_dis(ra_dis), .fast_dsel(fast_dsel)
   );

   function automatic logic [15:0] ixp();
      return strap_alt_base ? 16'h0078 : 16'h0178;
   endfunction

   task automatic finish_up();
      if (!ended) begin
         ended = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever the design returns a byte
   always @(negedge clk) begin
      if (rst_n && host_rvalid) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R10 unexpected rvalid actual=%0h expected=none", host_rdata);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(32'(host_rdata), 32'(e), t);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected<=20000", cyc);
         finish_up();
      end
   end

   task automatic wr_port(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd_port(input logic [15:0] a, input logic [7:0] e, input string tag);
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic wr_reg(input logic [7:0] ix, input logic [7:0] d);
      wr_port(ixp(), ix);
      wr_port(ixp() + 16'd4, d);
   endtask

   task automatic rd_reg(input logic [7:0] ix, input logic [7:0] e, input string tag);
      wr_port(ixp(), ix);
      rd_port(ixp() + 16'd4, e, tag);
   endtask

   task automatic chk_outs(input logic s, input logic [3:0] r, input logic f, input string tag);
      chk(32'({s, r, f}), 32'({s, r, f} == {s, r, f} ? {s, r, f} : 6'd0) , tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 reset state
      chk(32'({sec_chan_en, ra_dis, fast_dsel}), 32'd0, "R8 outputs after reset");
      chk(32'(host_rvalid), 32'd0, "R8 rvalid after reset");
      rd_port(16'h0178, 8'h00, "R8 index after reset");
      rd_reg(8'h59, 8'h40, "R8 burst reset");
      rd_reg(8'h51, 8'h00, "R8 ctrl reset");
      rd_reg(8'h5B, 8'h00, "R8 scratch reset");
      rd_reg(8'h50, 8'h01, "R3 cfg after reset");

      // R1 index readback
      wr_port(16'h0178, 8'h53);
      rd_port(16'h0178, 8'h53, "R1 index readback");

      // R3 read-only fields
      wr_reg(8'h50, 8'hFF);
      rd_reg(8'h50, 8'hDD, "R3 cfg ro bits after ff");
      wr_reg(8'h50, 8'h00);
      rd_reg(8'h50, 8'h01, "R3 cfg after 00");

      // R4 control decode
      wr_reg(8'h51, 8'h08);
      chk(32'({sec_chan_en, ra_dis, fast_dsel}), 32'b1_0000_0, "R4 secondary enable");
      wr_reg(8'h51, 8'hC0);
      chk(32'({sec_chan_en, ra_dis, fast_dsel}), 32'b0_0011_0, "R4 ra disable 0/1");

      // R6 fast device select
      wr_reg(8'h51, 8'h27);
      chk(32'(fast_dsel), 32'd1, "R6 fast full mask");
      wr_reg(8'h51, 8'h07);
      chk(32'(fast_dsel), 32'd0, "R6 fast partial 07");
      wr_reg(8'h51, 8'h25);
      chk(32'(fast_dsel), 32'd0, "R6 fast partial 25");
      wr_reg(8'h51, 8'h00);

      // R5 secondary read-ahead
      wr_reg(8'h57, 8'h04);
      chk(32'(ra_dis), 32'b0100, "R5 ra2");
      wr_reg(8'h57, 8'h08);
      chk(32'(ra_dis), 32'b1000, "R5 ra3");

      // R11 timing bytes
      wr_reg(8'h52, 8'hA5);
      wr_reg(8'h58, 8'h3C);
      rd_reg(8'h52, 8'hA5, "R11 timing 52");
      rd_reg(8'h58, 8'h3C, "R11 timing 58");
      rd_reg(8'h57, 8'h08, "R11 timing 57");

      // R7 scratch
      wr_reg(8'h5B, 8'hBD);
      rd_reg(8'h5B, 8'hBD, "R7 scratch bd");
      wr_reg(8'h5B, 8'h42);
      rd_reg(8'h5B, 8'h42, "R7 scratch 42");

      // R9 unimplemented
      wr_reg(8'h5A, 8'h55);
      rd_reg(8'h5A, 8'h00, "R9 unimpl 5a");
      rd_reg(8'h10, 8'h00, "R9 unimpl 10");
      rd_reg(8'h59, 8'h40, "R9 burst untouched");
      rd_reg(8'h5B, 8'h42, "R9 scratch untouched");

      // R2 wrong base ignored (strap 0)
      wr_port(16'h0178, 8'h51);
      wr_port(16'h0078, 8'h5B);
      wr_port(16'h007C, 8'hFF);
      chk(32'({sec_chan_en, ra_dis, fast_dsel}), 32'b0_1000_0, "R2 alt base ignored");
      @(negedge clk);
      host_addr = 16'h0100; host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      chk(32'(host_rvalid), 32'd0, "R2 no rvalid off port");
      rd_port(16'h0178, 8'h51, "R2 index kept");

      // R2 strap moves base
      @(negedge clk);
      strap_alt_base = 1'b1;
      rd_reg(8'h50, 8'h21, "R3 strap bit set");
      wr_port(16'h017C, 8'hFF);
      rd_port(16'h007C, 8'h21, "R2 old base ignored with strap");
      wr_reg(8'h51, 8'h08);
      chk(32'(sec_chan_en), 32'd1, "R2 alt base write");

      repeat (2) @(negedge clk);
      chk(32'(exp_q.size()), 32'd0, "R10 all reads returned");
      finish_up();
   end

endmodule